// File: doc/BRIEF.md
# Pipeline Stall and Bubble Control

This block controls the interstage registers of a five-stage in-order pipeline. The stages are fetch, address calculation, operand read, execute and write-back. Each stage register carries one valid bit, and this block owns those bits. It turns two stall requests of different reach into per-stage load enables for the datapath. A stall request from the address stage freezes fetch and address calculation. A stall request from the operand stage freezes the operand stage as well. Every register is clocked on the same edge, and only its load enable changes. The stage just below a frozen stage takes an invalid entry, so a bubble moves down the pipe, while the frozen stage keeps its own contents.

A taken branch in the write-back stage raises a flush, which invalidates every stage on the next edge. A skip request from a stage holding a valid instruction invalidates that instruction's successor. The successor is the nearest earlier stage that holds a valid entry, and bubbles in between are passed over. Side-effect strobes from the datapath, namely memory requests and register writes, are qualified with the valid bit of their stage. An invalid entry therefore never touches memory or the register file.

Stage vectors use bit 0 for fetch, bit 1 for address calculation, bit 2 for operand read, bit 3 for execute and bit 4 for write-back.

Top module: `pipe_bubble_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all bits of `stage_valid` are 0 after that edge.
- R2: With `of_stall` high, `stage_load` is 0 for bits 0, 1 and 2 and 1 for bits 3 and 4, and bit 3 of `stage_valid` is 0 after the edge.
- R3: With only `ac_stall` high, `stage_load` is 0 for bits 0 and 1 and 1 for bits 2 to 4, and bit 2 of `stage_valid` is 0 after the edge.
- R4: With `ac_stall` and `of_stall` both high, the result equals that of `of_stall` alone.
- R5: A stage whose `stage_load` is 0 keeps its valid bit unless a skip invalidates it.
- R6: `flush` clears every bit of `stage_valid` on the next edge, even while either stall is high, and it overrides `fetch_valid`.
- R7: A `skip_req[i]` with `stage_valid[i]` set clears the entry of the nearest lower stage whose valid bit is set, wherever that entry moves or stays on the edge. A skip from an invalid stage, or one with no valid stage below it, has no effect.
- R8: `mem_req_q[i]` equals `mem_req[i]` AND `stage_valid[i]`, and `reg_wr_q[i]` equals `reg_wr[i]` AND `stage_valid[i]`.
- R9: With no stall, flush or skip, each valid bit moves up one stage per clock, and `fetch_valid` enters bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A new instruction is available to enter the fetch stage |
| ac_stall | input | 1 | Freeze fetch and address calculation |
| of_stall | input | 1 | Freeze fetch, address calculation and operand read |
| flush | input | 1 | A branch was taken at write-back; invalidate all stages |
| skip_req | input | 5 | Per-stage skip request from the instruction in that stage |
| mem_req | input | 5 | Per-stage memory request before qualification |
| reg_wr | input | 5 | Per-stage register write before qualification |
| stage_load | output | 5 | Per-stage load enable for the datapath registers |
| stage_valid | output | 5 | Per-stage valid bit |
| mem_req_q | output | 5 | Memory request qualified by valid |
| reg_wr_q | output | 5 | Register write qualified by valid |

## Verification
A stall and a skip can fall in the same cycle. If the skipped instruction sits in a frozen stage, it must be invalidated in place. If it sits in the stage that is about to take a bubble, it must simply vanish. The bench loads a known valid pattern, raises the address-stage stall together with a skip from the operand stage, and compares the whole valid vector one edge later against a value worked out by hand. Flush combined with the wider stall is provoked in the same way, and the bench expects an empty pipe.

// File: rtl/pipe_ctrl_pkg.sv
// Package: shared defaults for the pipeline valid-bit controller.
// Assumes stage index 0 is fetch and indices grow toward write-back.
package pipe_ctrl_pkg;
    parameter int unsigned STAGES_DEF = 5;
    parameter int unsigned AC_IDX_DEF = 1;  // address calculation stage
    parameter int unsigned OF_IDX_DEF = 2;  // operand read stage
endpackage

// File: rtl/pbc_hold_mask.sv
// Module: pbc_hold_mask
// Turns the two stall requests into a per-stage hold vector.
// Assumes AC_IDX < OF_IDX < STAGES-1; the wider reach wins when both are high.
module pbc_hold_mask #(
    parameter int unsigned STAGES = pipe_ctrl_pkg::STAGES_DEF,
    parameter int unsigned AC_IDX = pipe_ctrl_pkg::AC_IDX_DEF,
    parameter int unsigned OF_IDX = pipe_ctrl_pkg::OF_IDX_DEF
) (
    input  logic              ac_stall,
    input  logic              of_stall,
    output logic [STAGES-1:0] hold
);
    for (genvar i = 0; i < STAGES; i++) begin : g_hold
        localparam bit IN_AC_REACH = (i <= AC_IDX);
        localparam bit IN_OF_REACH = (i <= OF_IDX);
        // hold a stage if it lies within the reach of an active stall
        assign hold[i] = (of_stall && IN_OF_REACH) || (ac_stall && IN_AC_REACH);
    end
endmodule

// File: rtl/pbc_skip_kill.sv
// Module: pbc_skip_kill
// For every valid stage requesting a skip, marks the nearest lower valid
// stage for invalidation, passing over bubbles. Purely combinational.
module pbc_skip_kill #(
    parameter int unsigned STAGES = pipe_ctrl_pkg::STAGES_DEF
) (
    input  logic [STAGES-1:0] valid,
    input  logic [STAGES-1:0] skip_req,
    output logic [STAGES-1:0] kill
);
    logic searching;

    // walk down from each skipping stage to the first valid successor
    always_comb begin
        kill      = '0;
        searching = 1'b0;
        for (int s = 0; s < STAGES; s++) begin
            searching = skip_req[s] && valid[s];
            for (int j = s - 1; j >= 0; j--) begin
                if (searching && valid[j]) begin
                    kill[j]   = 1'b1;
                    searching = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pbc_valid_regs.sv
// Module: pbc_valid_regs
// Holds the per-stage valid bits. Held stages keep their bit, the stage
// below a held stage takes a bubble, killed entries are cleared, and
// flush empties the pipe with top priority.
module pbc_valid_regs #(
    parameter int unsigned STAGES = pipe_ctrl_pkg::STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              flush,
    input  logic [STAGES-1:0] hold,
    input  logic [STAGES-1:0] kill,
    output logic [STAGES-1:0] valid
);
    logic [STAGES-1:0] valid_nxt;

    // next-state of each valid bit from hold, bubble and kill rules
    always_comb begin
        valid_nxt[0] = hold[0] ? (valid[0] && !kill[0]) : fetch_valid;
        for (int i = 1; i < STAGES; i++) begin
            if (hold[i])
                valid_nxt[i] = valid[i] && !kill[i];
            else if (hold[i-1])
                valid_nxt[i] = 1'b0;
            else
                valid_nxt[i] = valid[i-1] && !kill[i-1];
        end
    end

    // register the valid bits; reset and flush clear everything
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= '0;
        else if (flush)
            valid <= '0;
        else
            valid <= valid_nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> valid == '0); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid == '0); // R6

    for (genvar i = 0; i < STAGES; i++) begin : g_chk
        AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (hold[i] && !flush && !kill[i]) |=> valid[i] == $past(valid[i])); // R5
        if (i + 1 < STAGES) begin : g_bub
            AST_BUBBLE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
                (hold[i] && !hold[i+1]) |=> !valid[i+1]); // R5
        end
    end
endmodule

// File: rtl/pipe_bubble_ctrl.sv
// Module: pipe_bubble_ctrl (top)
// Interstage valid-bit and load-enable control for an in-order pipeline.
// Assumes the datapath loads a stage register only when stage_load is high
// and gates every side effect through the qualified strobes.
module pipe_bubble_ctrl #(
    parameter int unsigned STAGES = pipe_ctrl_pkg::STAGES_DEF,
    parameter int unsigned AC_IDX = pipe_ctrl_pkg::AC_IDX_DEF,
    parameter int unsigned OF_IDX = pipe_ctrl_pkg::OF_IDX_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              ac_stall,
    input  logic              of_stall,
    input  logic              flush,
    input  logic [STAGES-1:0] skip_req,
    input  logic [STAGES-1:0] mem_req,
    input  logic [STAGES-1:0] reg_wr,
    output logic [STAGES-1:0] stage_load,
    output logic [STAGES-1:0] stage_valid,
    output logic [STAGES-1:0] mem_req_q,
    output logic [STAGES-1:0] reg_wr_q
);
    logic [STAGES-1:0] hold;
    logic [STAGES-1:0] kill;

    pbc_hold_mask #(.STAGES(STAGES), .AC_IDX(AC_IDX), .OF_IDX(OF_IDX)) u_hold (
        .ac_stall (ac_stall),
        .of_stall (of_stall),
        .hold     (hold)
    );

    pbc_skip_kill #(.STAGES(STAGES)) u_kill (
        .valid    (stage_valid),
        .skip_req (skip_req),
        .kill     (kill)
    );

    pbc_valid_regs #(.STAGES(STAGES)) u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .flush       (flush),
        .hold        (hold),
        .kill        (kill),
        .valid       (stage_valid)
    );

    // datapath load enables are the inverse of the hold vector
    assign stage_load = ~hold;
    // side effects only from valid entries
    assign mem_req_q  = mem_req & stage_valid;
    assign reg_wr_q   = reg_wr & stage_valid;

    AST_OF_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        of_stall |-> stage_load[OF_IDX:0] == '0); // R4
    AST_AC_REACH: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_stall && !of_stall) |-> (stage_load[AC_IDX:0] == '0 && stage_load[AC_IDX+1])); // R3
    AST_OF_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        of_stall |=> !stage_valid[OF_IDX+1]); // R2
    AST_TOP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req[STAGES-1] && stage_valid[STAGES-1] && stage_valid[STAGES-2])
        |=> !stage_valid[STAGES-1]); // R7
endmodule

// File: tb/pipe_bubble_ctrl_bench.sv
// Directed bench for pipe_bubble_ctrl: one task per scenario.
module pipe_bubble_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 5;
    localparam int WATCHDOG = 5000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         fetch_valid;
    logic         ac_stall;
    logic         of_stall;
    logic         flush;
    logic [N-1:0] skip_req;
    logic [N-1:0] mem_req;
    logic [N-1:0] reg_wr;
    logic [N-1:0] stage_load;
    logic [N-1:0] stage_valid;
    logic [N-1:0] mem_req_q;
    logic [N-1:0] reg_wr_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pipe_bubble_ctrl u_pipe_bubble_ctrl (
        .clk, .rst_n, .fetch_valid, .ac_stall, .of_stall, .flush,
        .skip_req, .mem_req, .reg_wr,
        .stage_load, .stage_valid, .mem_req_q, .reg_wr_q
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0; ac_stall = 1'b0; of_stall = 1'b0; flush = 1'b0;
        skip_req = '0; mem_req = '0; reg_wr = '0;
    endtask

    // shift a valid pattern in through fetch; afterwards stage_valid == p
    task automatic load_pattern(input logic [N-1:0] p);
        idle_inputs();
        for (int k = N - 1; k >= 0; k--) begin
            fetch_valid = p[k];
            tick();
        end
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset();
        idle_inputs();
        fetch_valid = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        check("R1 reset valid", stage_valid, 5'b00000);
        rst_n = 1'b1;
    endtask

    task automatic t_advance();
        load_pattern(5'b10110);
        check("R9 shift pattern", stage_valid, 5'b10110);
        fetch_valid = 1'b1;
        tick();
        check("R9 one step", stage_valid, 5'b01101);
        idle_inputs();
    endtask

    task automatic t_of_stall();
        load_pattern(5'b11111);
        fetch_valid = 1'b1; of_stall = 1'b1;
        #1 check("R2 load enables", stage_load, 5'b11000);
        tick();
        check("R2 R5 bubble into execute", stage_valid, 5'b10111);
        idle_inputs();
    endtask

    task automatic t_ac_stall();
        load_pattern(5'b11111);
        fetch_valid = 1'b1; ac_stall = 1'b1;
        #1 check("R3 load enables", stage_load, 5'b11100);
        tick();
        check("R3 R5 bubble into operand", stage_valid, 5'b11011);
        idle_inputs();
    endtask

    task automatic t_both_stalls();
        load_pattern(5'b11111);
        fetch_valid = 1'b1; ac_stall = 1'b1; of_stall = 1'b1;
        #1 check("R4 load enables", stage_load, 5'b11000);
        tick();
        check("R4 wider hold", stage_valid, 5'b10111);
        idle_inputs();
    endtask

    task automatic t_flush();
        load_pattern(5'b11111);
        fetch_valid = 1'b1; of_stall = 1'b1; flush = 1'b1;
        tick();
        check("R6 flush over stall", stage_valid, 5'b00000);
        idle_inputs();
        load_pattern(5'b10101);
        fetch_valid = 1'b1; flush = 1'b1;
        tick();
        check("R6 flush over fetch", stage_valid, 5'b00000);
        idle_inputs();
    endtask

    task automatic t_skip();
        // skipper at top, bubble at 3, successor at 2
        load_pattern(5'b10101);
        skip_req = 5'b10000;
        tick();
        check("R7 skip passes bubble", stage_valid, 5'b00010);
        // skip from an invalid stage is ignored
        load_pattern(5'b00101);
        skip_req = 5'b10000;
        tick();
        check("R7 invalid skipper", stage_valid, 5'b01010);
        // no valid stage below the skipper
        load_pattern(5'b00001);
        skip_req = 5'b00001; fetch_valid = 1'b1;
        tick();
        check("R7 nothing below", stage_valid, 5'b00011);
        idle_inputs();
    endtask

    task automatic t_skip_with_stall();
        // successor frozen in address stage, skipper leaves a bubble behind
        load_pattern(5'b00110);
        skip_req = 5'b00100; ac_stall = 1'b1;
        tick();
        check("R7 R5 skip into held stage", stage_valid, 5'b01000);
        idle_inputs();
    endtask

    task automatic t_qualify();
        load_pattern(5'b10101);
        mem_req = 5'b11111; reg_wr = 5'b01110;
        #1;
        check("R8 memory strobe", mem_req_q, 5'b10101);
        check("R8 write strobe", reg_wr_q, 5'b00100);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        t_reset();
        t_advance();
        t_of_stall();
        t_ac_stall();
        t_both_stalls();
        t_flush();
        t_skip();
        t_skip_with_stall();
        t_qualify();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule